// File: doc/BRIEF.md
# Quadrature Encoder Input Conditioner

This block sits between the four raw encoder pins (phase A, phase B, index and home) and a quadrature decoder. Each pin is first brought into the clock domain, then optionally inverted, and phases A and B may be exchanged. The four signals then pass either straight through or through a digital glitch qualifier. The qualifier samples on ticks from a programmable prescaler that divides the clock by 1 to 256. A home rising edge can raise a one-cycle capture request for a downstream position counter.

Configuration is loaded as one word over a simple write strobe. The word takes effect on the clock edge that samples the strobe. The levels after polarity control are available at all times as status outputs, ahead of the swap and the qualifier.

Configuration word layout: bit 0 invert A, bit 1 invert B, bit 2 invert index, bit 3 invert home, bit 4 swap A/B, bit 5 qualifier enable, bits 8:6 divide select, bit 9 capture enable.

Top module: `quad_in_cond`

## Requirements
- R1: Each raw input passes through a two-stage synchronizer. A raw change made just after clock edge k shows on the status outputs after edge k+2. With the qualifier bypassed, it shows on the cleaned outputs after edge k+3.
- R2: Config bits 0 (A), 1 (B), 2 (index) and 3 (home) each invert their own input when set. When clear, the input passes unchanged.
- R3: When config bit 4 is set, the polarity-corrected A and B are exchanged before the qualifier, so outA follows B and outB follows A. Index and home are never swapped.
- R4: When config bit 5 is clear, the cleaned outputs follow the swapped signals one cycle later. When it is set, a cleaned output takes a new level only after the input has shown that level on 3 consecutive sample ticks. A level held for 2 ticks is rejected.
- R5: Config bits 8:6 select the sample-tick period in clock cycles: 0→1, 1→2, 2→4, 3→8, 4→16, 5→32, 6→64, 7→256.
- R6: A configuration write that changes the divide select restarts the prescaler. The first tick after the write is consumed D edges after the write edge, where D is the new divisor.
- R7: When config bit 9 is set, capReq is high for exactly the one cycle in which outHome rises. It stays low on a falling edge of outHome and whenever bit 9 is clear.
- R8: stA, stB, stIdx and stHome report the synchronized levels after polarity control only. They are unaffected by the swap and lead the qualifier.
- R9: After reset the configuration is all zero: no inversion, no swap, qualifier bypassed, divide by 1, capture disabled. All outputs are low while the raw inputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rawA | input | 1 | Raw phase A pin |
| rawB | input | 1 | Raw phase B pin |
| rawIdx | input | 1 | Raw index pin |
| rawHome | input | 1 | Raw home pin |
| cfgWrEn | input | 1 | Load configuration word on this edge |
| cfgWrData | input | 10 | Configuration word |
| stA | output | 1 | Phase A level after polarity |
| stB | output | 1 | Phase B level after polarity |
| stIdx | output | 1 | Index level after polarity |
| stHome | output | 1 | Home level after polarity |
| outA | output | 1 | Cleaned phase A to decoder |
| outB | output | 1 | Cleaned phase B to decoder |
| outIdx | output | 1 | Cleaned index to decoder |
| outHome | output | 1 | Cleaned home |
| capReq | output | 1 | One-cycle position capture request |

## Verification
The bench builds the block with its defaults: a largest divide exponent of 8, a qualifier length of 3 ticks and two synchronizer stages. These values are small enough that even the divide-by-256 setting settles within a few hundred cycles, so the bench sweeps every divide code. It measures the exact latency from a configuration write to the qualified edge, which exposes both the tick period and the prescaler restart. The 3-tick qualifier makes the accept/reject boundary between a 2-cycle and a 3-cycle pulse directly observable at divide by 1.

// File: rtl/quad_in_pkg.sv
package quad_in_pkg;

  localparam int NUM_CH = 4;
  localparam int SEL_W  = 3;

  // Channel order used for all 4-bit channel vectors
  localparam int CH_A    = 0;
  localparam int CH_B    = 1;
  localparam int CH_IDX  = 2;
  localparam int CH_HOME = 3;

  typedef struct packed {
    logic             capEn;
    logic [SEL_W-1:0] divSel;
    logic             filtEn;
    logic             swapAB;
    logic [NUM_CH-1:0] polMask;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // Settings the datapath needs from the control side
  typedef struct packed {
    logic              capEn;
    logic              swapAB;
    logic [NUM_CH-1:0] polMask;
  } chan_cfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic sampleTick;
    logic passThru;
  } strobe_t;

endpackage

// File: rtl/quad_in_ctrl.sv
module quad_in_ctrl
  import quad_in_pkg::*;
#(
  parameter int MAX_DIV_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output chan_cfg_t        chCfg,
  output strobe_t          strb
);

  localparam int PRE_W = MAX_DIV_LOG2;

  cfg_t cfgQ;
  cfg_t cfgNext;
  logic divChange;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preTerm;
  logic tickNow;

  // Terminal count for a divide code: code 7 jumps to the largest divisor
  function automatic logic [PRE_W-1:0] termFor(input logic [SEL_W-1:0] sel);
    int sh;
    sh = (sel == {SEL_W{1'b1}}) ? MAX_DIV_LOG2 : int'(sel);
    termFor = PRE_W'((64'd1 << sh) - 64'd1);
  endfunction

  assign cfgNext   = cfg_t'(cfgWrData);
  assign divChange = cfgWrEn && (cfgNext.divSel != cfgQ.divSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (cfgWrEn) begin
      cfgQ <= cfgNext;
    end
  end

  always_comb begin
    preTerm = termFor(cfgQ.divSel);
  end

  assign tickNow = (preCnt == preTerm);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (divChange || tickNow) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign chCfg.capEn   = cfgQ.capEn;
  assign chCfg.swapAB  = cfgQ.swapAB;
  assign chCfg.polMask = cfgQ.polMask;

  assign strb.sampleTick = tickNow;
  assign strb.passThru   = !cfgQ.filtEn;

endmodule

// File: rtl/quad_in_qual.sv
module quad_in_qual #(
  parameter int QUAL_TICKS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sampleIn,
  input  logic tick,
  input  logic passThru,
  output logic qualOut
);

  localparam int CNT_W = $clog2(QUAL_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_TICKS - 1);

  logic [CNT_W-1:0] agreeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualOut  <= 1'b0;
      agreeCnt <= '0;
    end else if (passThru) begin
      qualOut  <= sampleIn;
      agreeCnt <= '0;
    end else if (tick) begin
      if (sampleIn == qualOut) begin
        agreeCnt <= '0;
      end else if (agreeCnt == LAST) begin
        qualOut  <= sampleIn;
        agreeCnt <= '0;
      end else begin
        agreeCnt <= agreeCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/quad_in_dpath.sv
module quad_in_dpath
  import quad_in_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_TICKS  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] rawIn,
  input  chan_cfg_t         chCfg,
  input  strobe_t           strb,
  output logic [NUM_CH-1:0] levelPol,
  output logic [NUM_CH-1:0] cleanOut,
  output logic              capReq
);

  logic [NUM_CH-1:0] syncLvl;
  logic [NUM_CH-1:0] swapped;
  logic              homeDly;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sync
    logic [SYNC_STAGES-1:0] syncSh;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncSh <= '0;
      end else begin
        syncSh <= {syncSh[SYNC_STAGES-2:0], rawIn[c]};
      end
    end
    assign syncLvl[c] = syncSh[SYNC_STAGES-1];
  end

  assign levelPol = syncLvl ^ chCfg.polMask;

  always_comb begin
    swapped = levelPol;
    if (chCfg.swapAB) begin
      swapped[CH_A] = levelPol[CH_B];
      swapped[CH_B] = levelPol[CH_A];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_qual
    quad_in_qual #(
      .QUAL_TICKS(QUAL_TICKS)
    ) u_qual (
      .clk     (clk),
      .rstN    (rstN),
      .sampleIn(swapped[c]),
      .tick    (strb.sampleTick),
      .passThru(strb.passThru),
      .qualOut (cleanOut[c])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      homeDly <= 1'b0;
    end else begin
      homeDly <= cleanOut[CH_HOME];
    end
  end

  assign capReq = chCfg.capEn & cleanOut[CH_HOME] & ~homeDly;

endmodule

// File: rtl/quad_in_cond.sv
module quad_in_cond
  import quad_in_pkg::*;
#(
  parameter int MAX_DIV_LOG2 = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_TICKS   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawA,
  input  logic             rawB,
  input  logic             rawIdx,
  input  logic             rawHome,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic             stA,
  output logic             stB,
  output logic             stIdx,
  output logic             stHome,
  output logic             outA,
  output logic             outB,
  output logic             outIdx,
  output logic             outHome,
  output logic             capReq
);

  chan_cfg_t         chCfg;
  strobe_t           strb;
  logic [NUM_CH-1:0] levelPol;
  logic [NUM_CH-1:0] cleanOut;

  quad_in_ctrl #(
    .MAX_DIV_LOG2(MAX_DIV_LOG2)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgWrData(cfgWrData),
    .chCfg    (chCfg),
    .strb     (strb)
  );

  quad_in_dpath #(
    .SYNC_STAGES(SYNC_STAGES),
    .QUAL_TICKS (QUAL_TICKS)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   ({rawHome, rawIdx, rawB, rawA}),
    .chCfg   (chCfg),
    .strb    (strb),
    .levelPol(levelPol),
    .cleanOut(cleanOut),
    .capReq  (capReq)
  );

  assign stA     = levelPol[CH_A];
  assign stB     = levelPol[CH_B];
  assign stIdx   = levelPol[CH_IDX];
  assign stHome  = levelPol[CH_HOME];
  assign outA    = cleanOut[CH_A];
  assign outB    = cleanOut[CH_B];
  assign outIdx  = cleanOut[CH_IDX];
  assign outHome = cleanOut[CH_HOME];

endmodule

// File: rtl/quad_in_chk.sv
module quad_in_chk
  import quad_in_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic [CFG_W-1:0] cfgWrData,
  input logic [SEL_W-1:0] divSel,
  input strobe_t          strb,
  input logic [3:0]       outs,
  input logic             capReq
);

  cfg_t wrWord;
  assign wrWord = cfg_t'(cfgWrData);

  // R7: a request only accompanies a fresh rise of the cleaned home signal
  p_cap_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    capReq |-> (outs[3] && !$past(outs[3])));

  // R7: the request never lasts two cycles
  p_cap_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    capReq |=> !capReq);

  // R4: with qualifier active, outputs move only on a sample tick
  p_filter_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.passThru && !strb.sampleTick) |=> $stable(outs));

  // R5: for divisors of 2 and above, ticks never come back to back
  p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rstN)
    (divSel != '0 && strb.sampleTick) |=> (!strb.sampleTick || divSel == '0));

  // R6: changing to a divisor above 1 restarts the count, so no tick follows at once
  p_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && wrWord.divSel != divSel && wrWord.divSel != '0) |=> !strb.sampleTick);

endmodule

bind quad_in_cond quad_in_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgWrEn  (cfgWrEn),
  .cfgWrData(cfgWrData),
  .divSel   (u_ctrl.cfgQ.divSel),
  .strb     (strb),
  .outs     ({outHome, outIdx, outB, outA}),
  .capReq   (capReq)
);

// File: tb/quad_in_cond_tb_top.sv
`timescale 1ns/1ps
module quad_in_cond_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rawA = 1'b0, rawB = 1'b0, rawIdx = 1'b0, rawHome = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [9:0] cfgWrData = '0;
  logic stA, stB, stIdx, stHome, outA, outB, outIdx, outHome, capReq;

  int nChk = 0;
  int nBad = 0;
  int capCnt = 0;
  bit finished = 0;

  localparam logic [9:0] FILT = 10'h020;
  localparam logic [9:0] CAP  = 10'h200;
  localparam logic [9:0] POLH = 10'h008;

  // {cfg[9:0], raw{home,idx,b,a}, expected status, expected cleaned}
  localparam logic [21:0] VEC [9] = '{
    {10'h000, 4'b0000, 4'b0000, 4'b0000},
    {10'h000, 4'b0101, 4'b0101, 4'b0101},
    {10'h00F, 4'b0000, 4'b1111, 4'b1111},
    {10'h003, 4'b1001, 4'b1010, 4'b1010},
    {10'h010, 4'b0001, 4'b0001, 4'b0010},
    {10'h010, 4'b0010, 4'b0010, 4'b0001},
    {10'h011, 4'b0001, 4'b0000, 4'b0000},
    {10'h014, 4'b1110, 4'b1010, 4'b1001},
    {10'h008, 4'b1000, 4'b0000, 4'b0000}
  };

  always #10 clk = ~clk;

  quad_in_cond dut_i (
    .clk(clk), .rstN(rstN),
    .rawA(rawA), .rawB(rawB), .rawIdx(rawIdx), .rawHome(rawHome),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .stA(stA), .stB(stB), .stIdx(stIdx), .stHome(stHome),
    .outA(outA), .outB(outB), .outIdx(outIdx), .outHome(outHome),
    .capReq(capReq)
  );

  always @(negedge clk) if (rstN && capReq) capCnt++;

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic setRaw(input logic [3:0] r);
    {rawHome, rawIdx, rawB, rawA} = r;
  endtask

  task automatic wrCfg(input logic [9:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // Write config, raise raw A right after the write edge, count edges to outA rising
  task automatic measure(input logic [9:0] v, output int n);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrData = v;
    @(posedge clk);
    #1;
    cfgWrEn = 1'b0;
    rawA = 1'b1;
    n = 0;
    while (!outA && n < 2000) begin
      @(posedge clk);
      #1;
      n++;
    end
  endtask

  function automatic int expLatency(input int sel);
    int d;
    int k;
    d = (sel == 7) ? 256 : (1 << sel);
    k = (3 + d - 1) / d;
    return (k + 2) * d;
  endfunction

  initial begin
    int n;
    bit saw;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9: reset state
    chk("R9 status after reset", {stHome, stIdx, stB, stA}, 0);
    chk("R9 outputs after reset", {outHome, outIdx, outB, outA, capReq}, 0);

    // R1: synchronizer latency; R9 defaults: no invert, no swap, bypass, no capture
    @(posedge clk);
    #1;
    rawA = 1'b1;
    rawHome = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 status before edge k+2", stA, 0);
    @(negedge clk);
    chk("R1 status after edge k+2", stA, 1);
    chk("R1 out before edge k+3", outA, 0);
    @(negedge clk);
    chk("R1 out after edge k+3", outA, 1);
    chk("R9 default no swap", outB, 0);
    chk("R9 default home not inverted", outHome, 1);
    chk("R9 default capture off", capCnt, 0);

    // R2 R3 R8: polarity/swap table, qualifier bypassed
    for (int i = 0; i < 9; i++) begin
      wrCfg(VEC[i][21:12]);
      setRaw(VEC[i][11:8]);
      repeat (4) @(negedge clk);
      chk($sformatf("R2 R8 status vec%0d", i), {stHome, stIdx, stB, stA}, int'(VEC[i][7:4]));
      chk($sformatf("R3 cleaned vec%0d", i), {outHome, outIdx, outB, outA}, int'(VEC[i][3:0]));
    end
    chk("R7 no capture while disabled", capCnt, 0);

    // R7: capture requests
    setRaw(4'b0000);
    wrCfg(CAP);
    repeat (5) @(negedge clk);
    capCnt = 0;
    rawHome = 1'b1;
    repeat (6) @(negedge clk);
    chk("R7 one pulse on home rise", capCnt, 1);
    rawHome = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 no pulse on home fall", capCnt, 1);
    wrCfg(CAP | POLH);
    repeat (6) @(negedge clk);
    chk("R7 inverted home rises", capCnt, 2);
    rawHome = 1'b1;
    repeat (6) @(negedge clk);
    chk("R7 inverted home falls", capCnt, 2);
    rawHome = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 inverted home rises again", capCnt, 3);
    wrCfg(10'h000);
    repeat (6) @(negedge clk);
    rawHome = 1'b1;
    repeat (6) @(negedge clk);
    chk("R7 disabled capture", capCnt, 3);
    rawHome = 1'b0;

    // R4: glitch rejection at divide by 1
    wrCfg(FILT);
    repeat (6) @(negedge clk);
    rawA = 1'b1;
    repeat (2) @(negedge clk);
    rawA = 1'b0;
    saw = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (outA) saw = 1;
    end
    chk("R4 two-tick pulse rejected", saw, 0);
    rawA = 1'b1;
    repeat (3) @(negedge clk);
    rawA = 1'b0;
    saw = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (outA) saw = 1;
    end
    chk("R4 three-tick pulse accepted", saw, 1);
    repeat (8) @(negedge clk);
    chk("R4 returns low after held low", outA, 0);

    // R8: status leads the qualifier
    wrCfg(FILT | (10'd7 << 6));
    repeat (4) @(negedge clk);
    rawA = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 status ahead of qualifier", stA, 1);
    chk("R8 qualifier still old", outA, 0);

    // R5: every divide code, exact latency from write to qualified edge
    for (int sel = 0; sel < 8; sel++) begin
      wrCfg(10'h000);
      rawA = 1'b0;
      repeat (6) @(negedge clk);
      measure(FILT | (10'(sel) << 6), n);
      chk($sformatf("R5 latency divsel %0d", sel), n, expLatency(sel));
    end

    // R6: restart when divide select changes mid-count
    wrCfg(10'h000);
    rawA = 1'b0;
    repeat (6) @(negedge clk);
    wrCfg(FILT | (10'd7 << 6));
    repeat (100) @(negedge clk);
    measure(FILT | (10'd2 << 6), n);
    chk("R6 restart after divide change", n, 12);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule